// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block stores a stream of trace words in an on-chip memory that is used as a ring. Software programs a post-trigger word count and clears the write location. It then sets the enable bit. Every word accepted from the trace stream is then written at the write location, which advances by one per word and wraps at the end of memory. When the trigger input is seen, the block keeps storing the programmed number of further words and then stops by itself. It then raises a completion flag. A wrap flag tells software where the oldest valid entry lives. If the flag is set, reading starts at the write location; if it is clear, reading starts at zero and the write location is the entry count.

Reads and writes go through a plain address / write-data / strobe register port. Read data appears one cycle after the read strobe. Reading the data register returns the entry at the read location and steps that location forward, so software can drain the ring with repeated reads.

The trace input is a valid/ready stream. `trc_ready` is low only while reset is applied. From the first clock after reset it stays high, so the buffer never applies back-pressure. Words offered while capture is off are consumed and dropped. An accepted word sits in a one-word staging register for one cycle before it is written to memory, and the drained flag reports whether that register is empty.

Top module: `trace_ring_capture`

## Requirements
- R1: `trc_ready` is high from the first clock after reset. A word is accepted when `trc_valid` and `trc_ready` are both high while the enable bit (control register, address 0, bit 0) is set. A word offered while that bit is clear is dropped and leaves the write location unchanged.
- R2: Accepted words are written in acceptance order at the write location (address 4), which advances by one per word and wraps from DEPTH-1 to 0.
- R3: Status (address 1) bit 0, the wrap flag, is set when a word is written into location DEPTH-1.
- R4: A trigger seen while enabled sets status bit 1. After the word accepted in the trigger cycle, exactly the trigger-count value (address 6) further words are stored. Status bit 2 is then set and control bit 0 reads 0. Trigger-count writes above DEPTH are held at DEPTH.
- R5: A trigger while capture is disabled, or after completion, changes no status bit and stores nothing.
- R6: With a trigger count of 0, completion follows the trigger cycle, and only the word accepted in that cycle is stored after the trigger.
- R7: Status bit 3, the drained flag, is 0 while the staging register holds a word and 1 otherwise. It goes high no later than one cycle after bit 2.
- R8: Writing 0 to control bit 0 stops capture and keeps status bits 0 to 2. Writing 1 while capture is stopped clears status bits 0 to 2.
- R9: A write to the write location takes effect only while capture is stopped and the staging register is empty; otherwise it is ignored. A value of DEPTH or more loads 0.
- R10: The read location (address 5) is writable, with the same rule for values of DEPTH or more. Each read of address 7 returns the entry at the read location and advances the read location, wrapping from DEPTH-1 to 0.
- R11: Address 2 reads DEPTH and address 3 reads DATA_W. Read data for any address is presented on `reg_rdata` in the cycle after `reg_rd`. Control reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_valid | input | 1 | Trace word offered |
| trc_ready | output | 1 | Trace word can be taken |
| trc_data | input | DATA_W | Trace word |
| trig_in | input | 1 | Trigger event |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, one cycle after the strobe |

## Verification
Some behaviours are checked by assertions on every cycle:
- the pointer stepping and wrap of both locations;
- the write location staying put when nothing moves it;
- status flags holding while capture is off;
- the stop that accompanies completion;
- the flag clearing on re-arm;
- the drained flag rising one cycle after completion.

Other behaviours can only be shown by the bench's scenarios:
- the exact number of words kept after a trigger;
- the order of entries read back after a wrap;
- the zero-count trigger case;
- the rejection of a write-location update during capture;
- the loss of words and triggers offered while stopped.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_DEPTH = 3'd2,
    RA_WIDTH = 3'd3,
    RA_WPTR  = 3'd4,
    RA_RPTR  = 3'd5,
    RA_TCNT  = 3'd6,
    RA_DATA  = 3'd7
  } reg_addr_e;

  // Bit order matters: software decodes wrapped as bit 0 up to drained as bit 3.
  typedef struct packed {
    logic drained;
    logic done;
    logic triggered;
    logic wrapped;
  } status_t;

endpackage

// File: rtl/trc_intake.sv
module trc_intake #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              took,
  output logic              stg_valid,
  output logic [DATA_W-1:0] stg_data
);

  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= 1'b1;
  end

  assign in_ready = open_q;
  assign took     = in_valid && open_q && cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_valid <= 1'b0;
    else        stg_valid <= took;
  end

  always_ff @(posedge clk) begin
    if (took) stg_data <= in_data;
  end

  // R1: nothing offered while disabled reaches the staging register
  a_r1_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cap_en) |=> !stg_valid);

endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stg_valid,
  input  logic [DATA_W-1:0] stg_data,
  input  logic              wptr_wr,
  input  logic              rptr_wr,
  input  logic [WORD_W-1:0] ptr_wdata,
  input  logic              data_rd,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic [DATA_W-1:0] rd_word,
  output logic              wrap_evt
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam bit               POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wnext, rnext, ld_val;

  generate
    if (POW2) begin : g_natural_wrap
      assign wnext = wptr + PTR_W'(1);
      assign rnext = rptr + PTR_W'(1);
    end else begin : g_compare_wrap
      assign wnext = (wptr == LAST) ? '0 : wptr + PTR_W'(1);
      assign rnext = (rptr == LAST) ? '0 : rptr + PTR_W'(1);
    end
  endgenerate

  assign ld_val   = (ptr_wdata < WORD_W'(DEPTH)) ? ptr_wdata[PTR_W-1:0] : '0;
  assign wrap_evt = stg_valid && (wptr == LAST);
  assign rd_word  = mem[rptr];

  always_ff @(posedge clk) begin
    if (stg_valid) mem[wptr] <= stg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (stg_valid)    wptr <= wnext;
      else if (wptr_wr) wptr <= ld_val;
      if (rptr_wr)      rptr <= ld_val;
      else if (data_rd) rptr <= rnext;
    end
  end

  // R2: each stored word moves the write location one step, wrapping at the end
  a_r2_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid |=> (wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + PTR_W'(1))));

  // R9: with no store and no accepted load the write location holds
  a_r9_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stg_valid && !wptr_wr) |=> $stable(wptr));

  // R10: a data read steps the read location, wrapping at the end
  a_r10_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rptr_wr) |=> (rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + PTR_W'(1))));

endmodule

// File: rtl/trc_sequencer.sv
module trc_sequencer #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              tcnt_wr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              trig_in,
  input  logic              took,
  input  logic              wrap_evt,
  output logic              cap_en,
  output logic              triggered,
  output logic              done,
  output logic              wrapped,
  output logic [CNT_W-1:0]  tcnt
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] tcnt_load;
  logic             ctrl_en_bit, trig_take, post_word;

  assign ctrl_en_bit = cfg_wdata[0];
  assign tcnt_load   = (cfg_wdata > WORD_W'(DEPTH)) ? CNT_W'(DEPTH) : cfg_wdata[CNT_W-1:0];
  assign trig_take   = trig_in && cap_en && !triggered;
  assign post_word   = took && triggered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en    <= 1'b0;
      triggered <= 1'b0;
      done      <= 1'b0;
      wrapped   <= 1'b0;
      remain    <= '0;
      tcnt      <= '0;
    end else begin
      if (trig_take) begin
        triggered <= 1'b1;
        remain    <= tcnt;
        if (tcnt == '0) begin
          done   <= 1'b1;
          cap_en <= 1'b0;
        end
      end else if (post_word) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          done   <= 1'b1;
          cap_en <= 1'b0;
        end
      end
      if (wrap_evt) wrapped <= 1'b1;
      if (ctrl_wr) begin
        cap_en <= ctrl_en_bit;
        if (ctrl_en_bit && !cap_en) begin
          triggered <= 1'b0;
          done      <= 1'b0;
          wrapped   <= 1'b0;
        end
      end
      if (tcnt_wr) tcnt <= tcnt_load;
    end
  end

  // R4: completion always comes with capture switched off
  a_r4_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !cap_en);

  // R5: while stopped, only software can change trigger and completion flags
  a_r5_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !ctrl_wr) |=> ($stable(triggered) && $stable(done)));

  // R6: a zero count completes right after the trigger
  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_take && (tcnt == '0) && !ctrl_wr) |=> done);

  // R8: re-arming from stopped clears the flags and starts capture
  a_r8_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_en_bit && !cap_en) |=> (cap_en && !triggered && !done));

endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture
  import trc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trc_valid,
  output logic              trc_ready,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trig_in,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);

  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              cap_en, took, stg_valid, wrap_evt;
  logic [DATA_W-1:0] stg_data, rd_word;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  tcnt;
  logic              triggered, done, wrapped;
  logic              ctrl_wr, tcnt_wr, wptr_wr, rptr_wr, data_rd;
  status_t           stat;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign tcnt_wr = reg_wr && (reg_addr == RA_TCNT);
  assign wptr_wr = reg_wr && (reg_addr == RA_WPTR) && !cap_en && !stg_valid;
  assign rptr_wr = reg_wr && (reg_addr == RA_RPTR);
  assign data_rd = reg_rd && (reg_addr == RA_DATA);

  trc_intake #(.DATA_W(DATA_W)) u_intake (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .in_valid  (trc_valid),
    .in_data   (trc_data),
    .in_ready  (trc_ready),
    .took      (took),
    .stg_valid (stg_valid),
    .stg_data  (stg_data)
  );

  trc_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WORD_W(REG_W), .PTR_W(PTR_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .stg_valid (stg_valid),
    .stg_data  (stg_data),
    .wptr_wr   (wptr_wr),
    .rptr_wr   (rptr_wr),
    .ptr_wdata (reg_wdata),
    .data_rd   (data_rd),
    .wptr      (wptr),
    .rptr      (rptr),
    .rd_word   (rd_word),
    .wrap_evt  (wrap_evt)
  );

  trc_sequencer #(.DEPTH(DEPTH), .WORD_W(REG_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .tcnt_wr   (tcnt_wr),
    .cfg_wdata (reg_wdata),
    .trig_in   (trig_in),
    .took      (took),
    .wrap_evt  (wrap_evt),
    .cap_en    (cap_en),
    .triggered (triggered),
    .done      (done),
    .wrapped   (wrapped),
    .tcnt      (tcnt)
  );

  always_comb begin
    stat.drained   = !stg_valid;
    stat.done      = done;
    stat.triggered = triggered;
    stat.wrapped   = wrapped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= REG_W'(cap_en);
        RA_STAT:  reg_rdata <= REG_W'(stat);
        RA_DEPTH: reg_rdata <= REG_W'(DEPTH);
        RA_WIDTH: reg_rdata <= REG_W'(DATA_W);
        RA_WPTR:  reg_rdata <= REG_W'(wptr);
        RA_RPTR:  reg_rdata <= REG_W'(rptr);
        RA_TCNT:  reg_rdata <= REG_W'(tcnt);
        RA_DATA:  reg_rdata <= REG_W'(rd_word);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R1: the stream side is open from the first clock after reset
  a_r1_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> trc_ready);

  // R7: the staging register has emptied one cycle after completion
  a_r7_drained_lag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> !stg_valid);

endmodule

// File: tb/test_trace_ring_capture.sv
module test_trace_ring_capture;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DEPTH      = 16;
  localparam int unsigned DW         = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          b_valid = 1'b0;
  logic [DW-1:0] b_data = '0;
  logic          b_trig = 1'b0;
  logic [2:0]    b_addr = '0;
  logic          b_wr = 1'b0;
  logic          b_rd = 1'b0;
  logic [31:0]   b_wdata = '0;
  logic          trc_ready;
  logic [31:0]   rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_ring_capture #(.DATA_W(DW), .DEPTH(DEPTH), .REG_W(32)) i_trace_ring_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .trc_valid (b_valid),
    .trc_ready (trc_ready),
    .trc_data  (b_data),
    .trig_in   (b_trig),
    .reg_addr  (b_addr),
    .reg_wr    (b_wr),
    .reg_rd    (b_rd),
    .reg_wdata (b_wdata),
    .reg_rdata (rdata)
  );

  // Behavioural reference model, updated on every rising edge
  int          m_en, m_trg, m_done, m_full, m_sv, m_rdy, m_wp, m_rp, m_tc, m_rem;
  logic [31:0] m_sd;
  logic [31:0] exp_rd;
  logic [31:0] m_mem [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_trg = 0; m_done = 0; m_full = 0; m_sv = 0; m_rdy = 0;
      m_wp = 0; m_rp = 0; m_tc = 0; m_rem = 0; exp_rd = '0;
    end else begin : model_step
      int en0, trg0, sv0, tc0, acc;
      en0 = m_en; trg0 = m_trg; sv0 = m_sv; tc0 = m_tc;
      if (b_rd) begin
        case (b_addr)
          3'd0: exp_rd = 32'(m_en);
          3'd1: exp_rd = 32'((sv0 != 0 ? 0 : 8) + m_done * 4 + m_trg * 2 + m_full);
          3'd2: exp_rd = 32'(DEPTH);
          3'd3: exp_rd = 32'(DW);
          3'd4: exp_rd = 32'(m_wp);
          3'd5: exp_rd = 32'(m_rp);
          3'd6: exp_rd = 32'(m_tc);
          default: exp_rd = m_mem[m_rp];
        endcase
      end
      acc = (b_valid && m_rdy != 0 && en0 != 0) ? 1 : 0;
      if (sv0 != 0) begin
        m_mem[m_wp] = m_sd;
        if (m_wp == DEPTH - 1) m_full = 1;
        m_wp = (m_wp + 1) % DEPTH;
      end else if (b_wr && b_addr == 3'd4 && en0 == 0) begin
        m_wp = (b_wdata < DEPTH) ? int'(b_wdata) : 0;
      end
      if (b_wr && b_addr == 3'd5) m_rp = (b_wdata < DEPTH) ? int'(b_wdata) : 0;
      else if (b_rd && b_addr == 3'd7) m_rp = (m_rp + 1) % DEPTH;
      if (b_trig && en0 != 0 && trg0 == 0) begin
        m_trg = 1;
        if (tc0 == 0) begin m_done = 1; m_en = 0; end
        else m_rem = tc0;
      end else if (trg0 != 0 && acc != 0) begin
        m_rem = m_rem - 1;
        if (m_rem == 0) begin m_done = 1; m_en = 0; end
      end
      if (b_wr && b_addr == 3'd0) begin
        if (b_wdata[0] && en0 == 0) begin m_trg = 0; m_done = 0; m_full = 0; end
        m_en = b_wdata[0] ? 1 : 0;
      end
      if (b_wr && b_addr == 3'd6) m_tc = (b_wdata > DEPTH) ? DEPTH : int'(b_wdata);
      m_sv = acc;
      if (acc != 0) m_sd = b_data;
      m_rdy = 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R1: the stream side is compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n) check("R1 ready", 32'(trc_ready), 32'(m_rdy));
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    b_rd = 1'b1; b_addr = a;
    @(negedge clk);
    b_rd = 1'b0;
    check(tag, rdata, exp_rd);
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    b_valid = 1'b1; b_data = d; b_trig = t;
    @(negedge clk);
    b_valid = 1'b0; b_trig = 1'b0;
  endtask

  task automatic trig_only();
    b_trig = 1'b1;
    @(negedge clk);
    b_trig = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset values and size registers
    rd(3'd0, "R11 ctrl after reset");
    rd(3'd1, "R7 status after reset");
    rd(3'd2, "R11 depth");
    rd(3'd3, "R11 width");
    rd(3'd4, "R2 wptr after reset");

    // R1, R5: stimulus while stopped is ignored
    for (int i = 0; i < 3; i++) push(32'h0000_C000 + 32'(i), 1'b0);
    rd(3'd4, "R1 words dropped while off");
    trig_only();
    rd(3'd1, "R5 trigger while off");

    // R4, R7: trigger with three post-trigger words
    wr(3'd6, 32'd3);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd1);
    rd(3'd0, "R8 enable reads back");
    for (int i = 0; i < 5; i++) push(32'h0000_A000 + 32'(i), 1'b0);
    push(32'h0000_A005, 1'b1);
    for (int i = 6; i < 9; i++) push(32'h0000_A000 + 32'(i), 1'b0);
    rd(3'd1, "R7 last word still staged");
    push(32'h0000_A009, 1'b0);
    rd(3'd1, "R4 completion flags");
    rd(3'd4, "R4 words kept after trigger");
    rd(3'd0, "R4 enable cleared");
    push(32'h0000_B000, 1'b1);
    rd(3'd1, "R5 trigger after completion");
    wr(3'd5, 32'd0);
    for (int i = 0; i < 9; i++) rd(3'd7, "R10 linear readout");

    // R2, R3: wrap past the end of memory
    wr(3'd6, 32'd4);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd1);
    for (int i = 0; i < 20; i++) push(32'h0001_0000 + 32'(i), 1'b0);
    push(32'h0001_0014, 1'b1);
    for (int i = 21; i < 31; i++) push(32'h0001_0000 + 32'(i), 1'b0);
    rd(3'd1, "R3 wrap flag");
    rd(3'd4, "R2 wptr after wrap");
    wr(3'd5, 32'd9);
    for (int i = 0; i < 16; i++) rd(3'd7, "R2 oldest first after wrap");

    // R6, R8: zero post-trigger count, re-arm clears flags
    wr(3'd4, 32'd0);
    wr(3'd6, 32'd0);
    wr(3'd0, 32'd1);
    rd(3'd1, "R8 re-arm clears flags");
    push(32'h0002_0000, 1'b0);
    push(32'h0002_0001, 1'b0);
    push(32'h0002_0002, 1'b1);
    for (int i = 3; i < 6; i++) push(32'h0002_0000 + 32'(i), 1'b0);
    rd(3'd1, "R6 zero count completion");
    rd(3'd4, "R6 only trigger word kept");

    // R8, R9, R10: manual stop, pointer locking, read wrap
    wr(3'd6, 32'd5);
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd1);
    push(32'h0003_0000, 1'b0);
    push(32'h0003_0001, 1'b0);
    wr(3'd4, 32'd12);
    rd(3'd4, "R9 wptr write ignored while on");
    push(32'h0003_0002, 1'b1);
    wr(3'd0, 32'd0);
    rd(3'd0, "R8 stop reads back");
    rd(3'd1, "R8 flags kept on stop");
    push(32'h0003_0003, 1'b0);
    rd(3'd4, "R1 word dropped after stop");
    wr(3'd4, 32'd7);
    rd(3'd4, "R9 wptr load while stopped");
    wr(3'd6, 32'd100);
    rd(3'd6, "R4 count held at depth");
    wr(3'd5, 32'd15);
    rd(3'd7, "R10 last entry");
    rd(3'd7, "R10 wrapped entry");
    rd(3'd5, "R10 rptr wrapped");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule